// File: doc/BRIEF.md
# Configurable serial audio transmitter

This block turns 16-bit audio samples into a serial bit stream with a bit clock and a word select. A 32-bit write port fills an eight-word transmit queue. Each word carries two samples: the earlier one in bits 15:0 and the later one in bits 31:16. Once per frame the block takes what it needs from the queue and maps it onto the left and right channels. It then shifts each channel out one bit per bit clock while the word select marks which channel is on the line.

As a master, the block divides its system clock to make the bit clock and drives the word select itself. As a slave, it follows a bit clock and a word select from outside. Configuration inputs set the following:

- bit-clock polarity;
- whether data starts with the word-select edge or one bit later;
- a half-bit shift of the output;
- bit order;
- the channel half length;
- one of four channel mappings.

A frame that starts with too little queued data sends silence and pulses an underflow output. Configuration is expected to change only while `enable` is low.

Top module: `serial_audio_tx`

## Requirements
- R1: In mapping code 0 (stereo), each frame takes one queued word: bits 15:0 go out on the left channel and bits 31:16 on the right, MSB first when `lsb_first` is 0.
- R2: In mapping code 1 (mono, left only), each frame sends one sample on the left channel and zeros on the right. Samples are used in time order: bits 15:0 of a word first, then bits 31:16 of the same word, then the next word.
- R3: In mapping code 2 (mono, duplicated), each frame sends one sample, in the same order as R2, on both channels.
- R4: In mapping code 3 (downmix), each frame takes one word and sends floor((lo + hi) / 2) on both channels, with both halves read as two's-complement values.
- R5: With `late_start` at 0, the first data bit of a channel goes out in the first bit slot after the word-select change. With `late_start` at 1 it goes out one slot later. When the half length is 16, the last bit of each channel then lands in the first slot of the next channel.
- R6: In master mode, `sck_out` is the generated bit clock XOR `bck_invert`. Data changes on the falling edge of the un-inverted clock, which is the rising edge of `sck_out` when inverted.
- R7: With `half_shift` at 1, every data bit appears half a bit period later: it changes on the rising edge of the un-inverted bit clock instead of the falling edge.
- R8: With `lsb_first` at 1, each sample goes out least significant bit first.
- R9: Each channel lasts `half_len_sel` + 16 bit clocks (16 to 47). `ws_out` is 0 for left and 1 for right, and it changes only on a falling edge of the un-inverted bit clock. Slots after the sample bits carry 0.
- R10: The queue holds 8 words. `fifo_full` is 1 when 8 words are held, and a write while full is dropped.
- R11: A frame that starts without the data its mapping needs sends zeros on both channels and pulses `underflow` for one clock. Transmission resumes with queued data at the next frame start.
- R12: With `tx_off` at 1, `sd_out` stays 0 while clocks, framing and queue use carry on unchanged.
- R13: With `master` at 0, bit timing and channel come from `sck_in` (XOR `bck_invert`) and `ws_in`. A left channel starts when `ws_in` falls. `sck_out` and `ws_out` stay 0.
- R14: After reset and while `enable` is 0, `sd_out`, `ws_out` and `underflow` are 0, and `sck_out` equals `bck_invert` in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the interface; low resets framing and drops a held half-word |
| tx_off | input | 1 | Forces the data line to 0 |
| master | input | 1 | 1: generate bit clock and word select; 0: follow them |
| bck_invert | input | 1 | Inverts the bit clock |
| late_start | input | 1 | Starts data one bit after the word-select edge |
| half_shift | input | 1 | Delays the data output by half a bit period |
| lsb_first | input | 1 | Bit order select |
| half_len_sel | input | 5 | Channel length minus 16, in bit clocks |
| chan_mode | input | 2 | Channel mapping code 0..3 |
| wr_valid | input | 1 | Queue write strobe |
| wr_word | input | 32 | Two samples: earlier in 15:0, later in 31:16 |
| fifo_full | output | 1 | Queue holds 8 words |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | One-clock pulse at a starved frame start |

## Verification
The bench recovers every bit slot from the pins and compares it with a behavioural model of the queue and channel mapping.

- A 16-slot half combined with a late start checks the spilled last bit. A design that drops or misplaces that bit shows zeros or a shifted sample in slot 0.
- Mono mappings with an odd number of samples exercise the held second half-word. Wrong ordering swaps samples; a held half that is not cleared repeats one.
- Downmix words at the signed extremes catch averages computed unsigned or rounded the wrong way.
- A ninth write to a full queue, underflow frames and `tx_off` with queue accounting expose a queue that overwrites, stalls, or stops consuming while the line is silenced.

// File: rtl/satx_pkg.sv
package satx_pkg;
   typedef enum logic [1:0] {
      MAP_STEREO    = 2'd0,
      MAP_MONO_LEFT = 2'd1,
      MAP_MONO_DUP  = 2'd2,
      MAP_DOWNMIX   = 2'd3
   } chan_map_e;
endpackage

// File: rtl/satx_fifo.sv
module satx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          wr_ok, rd_ok;

   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
         if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
         cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
      end
   end

   // R10
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));

   // R10
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/satx_bitclk.sv
module satx_bitclk #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic master,
   input  logic invert,
   input  logic sck_in,
   output logic sck_int,
   output logic fall_ev,
   output logic rise_ev
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic tick, msck;
   logic s1, s2, s3;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (!run)                    cnt <= '0;
            else if (cnt == CW'(HALF_DIV-1))  cnt <= '0;
            else                              cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(HALF_DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msck <= 1'b0;
         s1 <= 1'b0;
         s2 <= 1'b0;
         s3 <= 1'b0;
      end else begin
         if (!run)      msck <= 1'b0;
         else if (tick) msck <= ~msck;
         s1 <= sck_in ^ invert;
         s2 <= s1;
         s3 <= s2;
      end
   end

   assign sck_int = master ? msck : s2;
   assign fall_ev = run && (master ? (tick && msck)  : (s3 && !s2));
   assign rise_ev = run && (master ? (tick && !msck) : (!s3 && s2));
endmodule

// File: rtl/satx_chanmap.sv
module satx_chanmap
   import satx_pkg::*;
#(
   parameter int SW = 16
) (
   input  chan_map_e       mode,
   input  logic [2*SW-1:0] word,
   input  logic            have_word,
   input  logic [SW-1:0]   spare,
   input  logic            spare_vld,
   output logic [SW-1:0]   left,
   output logic [SW-1:0]   right,
   output logic            pop,
   output logic            take_spare,
   output logic            load_spare,
   output logic            starve
);
   logic [SW-1:0] lo, hi, mono;
   logic [SW:0]   sum;

   assign lo   = word[SW-1:0];
   assign hi   = word[2*SW-1:SW];
   assign sum  = {lo[SW-1], lo} + {hi[SW-1], hi};
   assign mono = spare_vld ? spare : lo;

   always_comb begin
      left = '0;
      right = '0;
      pop = 1'b0;
      take_spare = 1'b0;
      load_spare = 1'b0;
      starve = 1'b0;
      unique case (mode)
         MAP_STEREO: begin
            starve = !have_word;
            pop    = have_word;
            left   = lo;
            right  = hi;
         end
         MAP_MONO_LEFT, MAP_MONO_DUP: begin
            starve     = !spare_vld && !have_word;
            take_spare = spare_vld;
            pop        = !spare_vld && have_word;
            load_spare = !spare_vld && have_word;
            left       = mono;
            right      = (mode == MAP_MONO_DUP) ? mono : '0;
         end
         default: begin
            starve = !have_word;
            pop    = have_word;
            left   = sum[SW:1];
            right  = sum[SW:1];
         end
      endcase
      if (starve) begin
         left  = '0;
         right = '0;
      end
   end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
   import satx_pkg::*;
#(
   parameter int SW         = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int HALF_DIV   = 2,
   parameter int LEN_BITS   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                tx_off,
   input  logic                master,
   input  logic                bck_invert,
   input  logic                late_start,
   input  logic                half_shift,
   input  logic                lsb_first,
   input  logic [LEN_BITS-1:0] half_len_sel,
   input  logic [1:0]          chan_mode,
   input  logic                wr_valid,
   input  logic [2*SW-1:0]     wr_word,
   output logic                fifo_full,
   input  logic                sck_in,
   input  logic                ws_in,
   output logic                sck_out,
   output logic                ws_out,
   output logic                sd_out,
   output logic                underflow
);
   localparam int WW = 2 * SW;
   localparam int KW = $clog2(SW + (1 << LEN_BITS));
   localparam int PW = $clog2(SW);

   generate
      if (SW < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || HALF_DIV < 1) begin : g_bad_param
         $error("serial_audio_tx: unsupported parameter set");
      end
   endgenerate

   logic          fall_ev, rise_ev, sck_int;
   logic [WW-1:0] rd_word;
   logic          fifo_empty, rd_en;
   logic [SW-1:0] map_l, map_r;
   logic          pop, take_spare, load_spare, starve;

   logic [KW-1:0] k, k_n, half_len, last, idx;
   logic          ws, ws_n, wrap, frame_start;
   logic [SW-1:0] lq, rq, spare, cur, cur_n;
   logic          spare_vld, sd_q, sd_late, uf_q;
   logic          in_rng, spill_n, bit_n;
   logic [PW-1:0] pos;

   satx_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(enable), .master(master),
      .invert(bck_invert), .sck_in(sck_in), .sck_int(sck_int),
      .fall_ev(fall_ev), .rise_ev(rise_ev));

   satx_fifo #(.W(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_valid), .wr_data(wr_word),
      .rd_en(rd_en), .rd_data(rd_word), .empty(fifo_empty), .full(fifo_full));

   satx_chanmap #(.SW(SW)) u_map (
      .mode(chan_map_e'(chan_mode)), .word(rd_word), .have_word(!fifo_empty),
      .spare(spare), .spare_vld(spare_vld), .left(map_l), .right(map_r),
      .pop(pop), .take_spare(take_spare), .load_spare(load_spare), .starve(starve));

   // framing position for the slot that starts at the next falling edge
   assign half_len = KW'(SW) + KW'(half_len_sel);
   assign last     = half_len - 1'b1;

   always_comb begin
      if (master) begin
         wrap = (k >= last);
         ws_n = wrap ? ~ws : ws;
         k_n  = wrap ? '0 : k + 1'b1;
      end else begin
         wrap = (ws_in != ws);
         ws_n = ws_in;
         k_n  = wrap ? '0 : ((&k) ? k : k + 1'b1);
      end
   end

   assign frame_start = fall_ev && wrap && !ws_n;
   assign rd_en       = frame_start && pop;

   // data bit for the coming slot
   assign cur     = ws ? rq : lq;
   assign cur_n   = ws_n ? (frame_start ? map_r : rq) : (frame_start ? map_l : lq);
   assign spill_n = lsb_first ? cur[SW-1] : cur[0];
   assign idx     = k_n - KW'(late_start);
   assign in_rng  = (k_n >= KW'(late_start)) && (idx < KW'(SW));
   assign pos     = lsb_first ? idx[PW-1:0] : PW'(SW - 1) - idx[PW-1:0];

   always_comb begin
      if (in_rng)
         bit_n = cur_n[pos];
      else if (late_start && k_n == '0 && half_len == KW'(SW))
         bit_n = spill_n;
      else
         bit_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k <= '1;
         ws <= 1'b1;
         lq <= '0;
         rq <= '0;
         spare <= '0;
         spare_vld <= 1'b0;
         sd_q <= 1'b0;
         sd_late <= 1'b0;
         uf_q <= 1'b0;
      end else begin
         uf_q <= 1'b0;
         if (!enable) begin
            k <= last;
            ws <= 1'b1;
            lq <= '0;
            rq <= '0;
            spare_vld <= 1'b0;
            sd_q <= 1'b0;
            sd_late <= 1'b0;
         end else begin
            if (fall_ev) begin
               k <= k_n;
               ws <= ws_n;
               sd_q <= bit_n;
               if (frame_start) begin
                  lq <= map_l;
                  rq <= map_r;
                  uf_q <= starve;
                  if (take_spare) spare_vld <= 1'b0;
                  else if (load_spare) begin
                     spare <= rd_word[WW-1:SW];
                     spare_vld <= 1'b1;
                  end
               end
            end
            if (rise_ev) sd_late <= sd_q;
         end
      end
   end

   assign sd_out    = tx_off ? 1'b0 : (half_shift ? sd_late : sd_q);
   assign sck_out   = master ? (sck_int ^ bck_invert) : 1'b0;
   assign ws_out    = (master && enable) ? ws : 1'b0;
   assign underflow = uf_q;

   // R9
   ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && master && (ws != $past(ws))) |-> ($past(sck_int) && !sck_int));

   // R9
   slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && master && $stable(half_len_sel)) |-> (k <= last));

   // R11
   starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(fifo_empty));
endmodule

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int SLV_HALF   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 0, tx_off = 0, master = 1, bck_invert = 0, late_start = 0;
   logic half_shift = 0, lsb_first = 0;
   logic [4:0] half_len_sel = '0;
   logic [1:0] chan_mode = '0;
   logic wr_valid = 0;
   logic [31:0] wr_word = '0;
   logic sck_in = 0, ws_in = 1;
   logic fifo_full, sck_out, ws_out, sd_out, underflow;

   serial_audio_tx uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tx_off(tx_off), .master(master),
      .bck_invert(bck_invert), .late_start(late_start), .half_shift(half_shift),
      .lsb_first(lsb_first), .half_len_sel(half_len_sel), .chan_mode(chan_mode),
      .wr_valid(wr_valid), .wr_word(wr_word), .fifo_full(fifo_full),
      .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .ws_out(ws_out),
      .sd_out(sd_out), .underflow(underflow));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural model state
   logic [31:0] q[$];
   logic [15:0] m_sp, m_l, m_r, cur;
   bit   m_spv;
   int   m_uf = 0, seen_uf = 0;
   int   cfg_L = 16;
   string tag = "R14";

   // monitor state
   bit   mon_on = 0, started = 0, done = 0;
   logic prev_sck = 0, ws_rise = 1, prev_w = 1, ws_last = 1, spill = 0;
   int   slot = 0, frames = 0, target = 0;

   // slave stimulus state
   bit   slave_go = 0;
   logic s_log = 0;
   int   s_cnt = 0, s_slot = 0;

   function automatic logic exp_bit(logic [15:0] s, int kk, logic sp);
      int j = kk - int'(late_start);
      if (j >= 0 && j < 16) return lsb_first ? s[j] : s[15 - j];
      if (late_start && kk == 0 && cfg_L == 16) return sp;
      return 1'b0;
   endfunction

   task automatic frame_load();
      logic [31:0] w;
      logic [15:0] s;
      int a, b;
      m_l = '0;
      m_r = '0;
      case (chan_mode)
         2'd0, 2'd3: begin
            if (q.size() == 0) m_uf++;
            else begin
               w = q.pop_front();
               if (chan_mode == 2'd0) begin
                  m_l = w[15:0];
                  m_r = w[31:16];
               end else begin
                  a = int'($signed(w[15:0]));
                  b = int'($signed(w[31:16]));
                  a = (a + b) >>> 1;
                  m_l = a[15:0];
                  m_r = a[15:0];
               end
            end
         end
         default: begin
            if (m_spv) begin
               s = m_sp;
               m_spv = 0;
            end else if (q.size() != 0) begin
               w = q.pop_front();
               s = w[15:0];
               m_sp = w[31:16];
               m_spv = 1;
            end else begin
               m_uf++;
               s = '0;
            end
            m_l = s;
            m_r = (chan_mode == 2'd2) ? s : 16'h0;
         end
      endcase
   endtask

   task automatic process_slot(logic w);
      if (!started && w == 1'b1) begin
         chk({tag, " idle before first frame"}, sd_out, 0);
         return;
      end
      if (!started || w != prev_w) begin
         if (started) begin
            // R9: channel length in bit clocks
            chk("R9 half length", slot, cfg_L);
            spill = lsb_first ? cur[15] : cur[0];
         end else spill = 1'b0;
         started = 1;
         prev_w = w;
         slot = 0;
         if (w == 1'b0) begin
            frame_load();
            frames++;
         end
         cur = w ? m_r : m_l;
      end
      chk(tag, sd_out, tx_off ? 0 : exp_bit(cur, slot, spill));
      slot++;
      if (frames >= target && w == 1'b1 && slot >= 2) done = 1;
   endtask

   initial forever begin
      logic lsck, wsv, rise, fall;
      @(negedge clk);
      if (underflow) seen_uf++;
      if (mon_on) begin
         lsck = master ? (sck_out ^ bck_invert) : s_log;
         wsv  = master ? ws_out : ws_in;
         rise = lsck && !prev_sck;
         fall = !lsck && prev_sck;
         if (master && wsv != ws_last) chk("R9 ws moves on falling edge", fall, 1);
         if (!master) begin
            // R13: generated pins stay low in slave mode
            chk("R13 sck_out quiet", sck_out, 0);
            chk("R13 ws_out quiet", ws_out, 0);
         end
         if (rise) ws_rise = wsv;
         if (half_shift ? fall : rise) process_slot(ws_rise);
         prev_sck = lsck;
         ws_last = wsv;
      end
   end

   // slave-side bit clock and word select
   initial forever begin
      @(posedge clk);
      #1;
      if (!slave_go) begin
         s_log = 0;
         ws_in = 1;
         s_cnt = 0;
         s_slot = cfg_L - 1;
      end else begin
         s_cnt++;
         if (s_cnt == SLV_HALF) begin
            s_cnt = 0;
            if (s_log) begin
               s_log = 0;
               if (s_slot >= cfg_L - 1) begin
                  s_slot = 0;
                  ws_in = ~ws_in;
               end else s_slot++;
            end else s_log = 1;
         end
      end
      sck_in = s_log ^ bck_invert;
   end

   task automatic put(logic [31:0] w);
      @(posedge clk);
      #1;
      wr_valid = 1;
      wr_word = w;
      if (q.size() < 8) q.push_back(w);
      @(posedge clk);
      #1;
      wr_valid = 0;
   endtask

   task automatic run_case(string t, logic [1:0] mode, logic inv, logic late, logic hs,
                           logic lsb, logic [4:0] sel, logic mst, logic off, int nfr);
      int uf0, suf0;
      @(posedge clk);
      #1;
      tag = t;
      chan_mode = mode;
      bck_invert = inv;
      late_start = late;
      half_shift = hs;
      lsb_first = lsb;
      half_len_sel = sel;
      master = mst;
      tx_off = off;
      cfg_L = int'(sel) + 16;
      repeat (3) @(posedge clk);
      #1;
      uf0 = m_uf;
      suf0 = seen_uf;
      started = 0;
      done = 0;
      frames = 0;
      target = nfr;
      slot = 0;
      prev_sck = 0;
      ws_rise = 1;
      ws_last = 1;
      cur = '0;
      enable = 1;
      slave_go = !mst;
      mon_on = 1;
      wait (done);
      @(posedge clk);
      #1;
      mon_on = 0;
      enable = 0;
      slave_go = 0;
      m_spv = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R14: disabled state
      chk("R14 sd_out idle", sd_out, 0);
      chk("R14 ws_out idle", ws_out, 0);
      chk("R14 sck_out idle", sck_out, mst ? int'(inv) : 0);
      // R11: one pulse per starved frame
      chk({"R11 underflow count in ", t}, seen_uf - suf0, m_uf - uf0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R14: reset state
      chk("R14 reset sd_out", sd_out, 0);
      chk("R14 reset ws_out", ws_out, 0);
      chk("R14 reset underflow", underflow, 0);
      chk("R14 reset sck_out", sck_out, 0);
      chk("R10 reset fifo_full", fifo_full, 0);
      @(posedge clk);
      #1;
      rst_n = 1;

      // R1 stereo
      put(32'h1234_A5C3); put(32'h8001_7FFE); put(32'h0F0F_F0F0); put(32'hFFFF_0000);
      run_case("R1 stereo", 2'd0, 0, 0, 0, 0, 5'd0, 1, 0, 4);
      // R5 late start, spill at 16-slot halves, then longer halves
      put(32'hC001_8003); put(32'h5555_AAAA); put(32'h0001_8000);
      run_case("R5 late start 16", 2'd0, 0, 1, 0, 0, 5'd0, 1, 0, 3);
      put(32'h9ABC_DEF1); put(32'h2468_1357);
      run_case("R5 late start 20", 2'd0, 0, 1, 0, 0, 5'd4, 1, 0, 2);
      // R2 mono left, odd sample count
      put(32'h1111_2222); put(32'h3333_4444); put(32'h5555_6666);
      run_case("R2 mono left", 2'd1, 0, 0, 0, 0, 5'd2, 1, 0, 5);
      // R3 duplicated mono
      put(32'hBEEF_CAFE); put(32'h0123_4567);
      run_case("R3 mono dup", 2'd2, 0, 0, 0, 0, 5'd8, 1, 0, 4);
      // R4 downmix at signed extremes
      put(32'h8000_8000); put(32'h7FFF_7FFF); put(32'h0001_FFFF); put(32'h0003_0000);
      put(32'h8000_7FFF); put(32'hFFFD_0000);
      run_case("R4 downmix", 2'd3, 0, 0, 0, 0, 5'd1, 1, 0, 6);
      // R6 inverted bit clock
      put(32'hA0A0_0B0B); put(32'h7E57_C0DE);
      run_case("R6 inverted clock", 2'd0, 1, 0, 0, 0, 5'd0, 1, 0, 2);
      // R7 half-bit output shift
      put(32'hF00D_D00F); put(32'h1357_9BDF);
      run_case("R7 half shift", 2'd0, 0, 0, 1, 0, 5'd3, 1, 0, 2);
      // R8 lsb first, combined with late start and spill
      put(32'h8421_1248); put(32'h0003_C000);
      run_case("R8 lsb first", 2'd0, 0, 1, 0, 1, 5'd0, 1, 0, 2);
      // R9 longest half
      put(32'hDEAD_BEEF);
      run_case("R9 longest half", 2'd0, 0, 0, 0, 0, 5'd31, 1, 0, 1);
      // R10 full queue drops the ninth write
      put(32'h0000_0001);
      @(negedge clk);
      chk("R10 not full at one word", fifo_full, 0);
      for (int i = 2; i <= 8; i++) put(32'h0100_0000 * i + i);
      @(negedge clk);
      chk("R10 full at eight words", fifo_full, 1);
      put(32'hFFFF_FFFF);
      @(negedge clk);
      chk("R10 still full after drop", fifo_full, 1);
      run_case("R10 dropped write", 2'd0, 0, 0, 0, 0, 5'd0, 1, 0, 9);
      // R11 underflow then silence
      put(32'h4321_8765);
      run_case("R11 underflow", 2'd2, 0, 0, 0, 0, 5'd0, 1, 0, 4);
      // R12 data line forced low, queue still used
      put(32'hFFFF_FFFF); put(32'hFFFF_FFFF);
      run_case("R12 tx off", 2'd0, 0, 0, 0, 0, 5'd0, 1, 1, 4);
      // R13 slave timing, with and without half shift
      put(32'h6C6C_9393); put(32'h0FF0_F00F); put(32'hA5A5_5A5A);
      run_case("R13 slave", 2'd0, 0, 1, 0, 0, 5'd2, 0, 0, 3);
      put(32'h1F2E_3D4C); put(32'h7A6B_5C4D);
      run_case("R13 slave inverted shifted", 2'd0, 1, 0, 1, 0, 5'd0, 0, 0, 2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule